// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a synthesizable behavioural model of a single-port static RAM that works entirely from the rising clock edge. A word has four lanes of nine bits each. The depth is set by the address width. An access begins when an address strobe arrives while all three chip selects are active. The address is then held in a register. Its two low bits act as a burst counter, which an advance input steps through a four-word block in linear order. The upper bits do not change during the burst.

Writes can take one of two forms. A global write updates every lane of the word. A qualified byte write updates only the lanes whose select is low. Read data goes through two register stages on its way to the output. A combinational output-enable input gates the drive flag for the data-out bus. The bidirectional pins appear as separate input data, output data and a drive flag.

Top module: `burst_sram`

## Requirements
- R1: An access starts when an address strobe is low. If, at that edge, `sel_a_n` is not low, `sel_b` is not high or `sel_c_n` is not low, the block becomes deselected. Memory is then left untouched until a later start with all three selects active.
- R2: A start with all selects active loads `addr` into the address register. A start means `ctl_strb_n` low, or `cpu_strb_n` low together with `sel_a_n` low. That address is the address of the access at this same edge.
- R3: When `sel_a_n` is high, the block ignores `cpu_strb_n`. A selected block with `cpu_strb_n` low, `ctl_strb_n` high and `step_n` high keeps its current address.
- R4: In a selected cycle with no start and `step_n` low, the low two address bits go up by one, wrapping from 3 to 0. The upper address bits stay the same.
- R5: In a selected cycle with no start and `step_n` high, the address does not change. The cycle accesses that address again.
- R6: A selected access with `wr_all_n` low writes all four lanes from `din`. This happens whatever `wr_byte_n` and `lane_sel_n` are set to. Lane k is `din[9k+8:9k]`.
- R7: A selected access with `wr_all_n` high and `wr_byte_n` low is a write. It updates only the lanes k where `lane_sel_n[k]` is low. If every select is high, nothing is updated.
- R8: A start caused by `cpu_strb_n` is always a read, even when the write inputs are asserted.
- R9: A read access at edge k puts that word on `dout` after edge k+1. Any access that is not a write is a read.
- R10: `dout_en` is high only when `oe_n` is low and the output stage holds read data. `oe_n` acts on `dout_en` without waiting for a clock edge.
- R11: In the cycle that follows a start made from the deselected state, `dout_en` stays low even when `oe_n` is low.
- R12: While `rst_n` is low, `dout_en` is low and the block is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every control is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address, loaded at a start |
| sel_a_n | input | 1 | Chip select, active low; also qualifies the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | High when the data bus is driven |

## Verification
The properties assume that every control input has a defined level at each rising edge. They also assume that `oe_n` is steady whenever it is sampled. Under those assumptions, the pipeline flags and the address register follow only from the strobe, select and advance rules.

The stimulus changes every input on the falling edge. The one exception is `oe_n`, which is pulsed mid-cycle on purpose. The bench first fills every word with a global write. This means every later read comes from a defined location. Every burst in the stimulus stays inside the parameter defaults that the bench model mirrors.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2,
   parameter int LANES   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              cpu_strb_n,
   input  logic              ctl_strb_n,
   input  logic              step_n,
   input  logic              wr_all_n,
   input  logic              wr_byte_n,
   input  logic [LANES-1:0]  lane_sel_n,
   output logic              start,
   output logic              sel_ok,
   output logic              cpu_go,
   output logic              active,
   output logic [ADDR_W-1:0] cur_addr,
   output acc_kind_e         acc_kind,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [LANES-1:0]  lane_we
);

   localparam int HI_W = ADDR_W - BURST_W;

   logic              nxt_active;
   logic [ADDR_W-1:0] nxt_addr;
   logic [BURST_W-1:0] lo_inc;
   logic [HI_W-1:0]   hi_keep;
   logic              wr_req;

   assign lo_inc  = cur_addr[BURST_W-1:0] + BURST_W'(1);
   assign hi_keep = cur_addr[ADDR_W-1:BURST_W];

   always_comb begin
      sel_ok     = !sel_a_n && sel_b && !sel_c_n;
      cpu_go     = !cpu_strb_n && !sel_a_n;
      start      = cpu_go || !ctl_strb_n;
      wr_req     = !wr_all_n || !wr_byte_n;
      nxt_active = active;
      nxt_addr   = cur_addr;
      acc_kind   = ACC_NONE;
      if (start) begin
         if (sel_ok) begin
            nxt_active = 1'b1;
            nxt_addr   = addr;
            acc_kind   = (!cpu_go && wr_req) ? ACC_WRITE : ACC_READ;
         end else begin
            nxt_active = 1'b0;
         end
      end else if (active) begin
         if (!step_n) begin
            nxt_addr = {hi_keep, lo_inc};
         end
         acc_kind = wr_req ? ACC_WRITE : ACC_READ;
      end
   end

   assign acc_addr = nxt_addr;

   always_comb begin
      lane_we = '0;
      if (acc_kind == ACC_WRITE) begin
         lane_we = !wr_all_n ? {LANES{1'b1}} : ~lane_sel_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cur_addr <= '0;
      end else begin
         active   <= nxt_active;
         cur_addr <= nxt_addr;
      end
   end

endmodule

// File: rtl/byte_array.sv
module byte_array #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int ADDR_W = 6
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        lane_we,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[g]) begin
            cells[addr] <= wdata[g*LANE_W +: LANE_W];
         end
      end

      assign rdata[g*LANE_W +: LANE_W] = cells[addr];
   end

endmodule

// File: rtl/read_pipe.sv
module read_pipe #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              out_vld,
   output logic              dout_en
);

   logic              s1_vld;
   logic [DATA_W-1:0] s1_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         out_vld <= 1'b0;
      end else begin
         s1_vld  <= rd_fire;
         out_vld <= s1_vld;
      end
   end

   always_ff @(posedge clk) begin
      s1_data <= rd_data;
      dout    <= s1_data;
   end

   assign dout_en = out_vld && !oe_n;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int LANE_W  = 9,
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    cpu_strb_n,
   input  logic                    ctl_strb_n,
   input  logic                    step_n,
   input  logic                    wr_all_n,
   input  logic                    wr_byte_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_en
);

   localparam int DATA_W = LANES * LANE_W;

   if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
      $error("burst_sram: BURST_W must lie in 1..ADDR_W-1");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("burst_sram: LANES and LANE_W must be positive");
   end

   logic              start_w;
   logic              sel_ok_w;
   logic              cpu_go_w;
   logic              active_w;
   logic [ADDR_W-1:0] cur_addr_w;
   acc_kind_e         acc_kind_w;
   logic [ADDR_W-1:0] acc_addr_w;
   logic [LANES-1:0]  lane_we_w;
   logic [DATA_W-1:0] rdata_w;
   logic              rd_fire_w;
   logic              out_vld_w;

   burst_ctl #(
      .ADDR_W  (ADDR_W),
      .BURST_W (BURST_W),
      .LANES   (LANES)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (addr),
      .sel_a_n    (sel_a_n),
      .sel_b      (sel_b),
      .sel_c_n    (sel_c_n),
      .cpu_strb_n (cpu_strb_n),
      .ctl_strb_n (ctl_strb_n),
      .step_n     (step_n),
      .wr_all_n   (wr_all_n),
      .wr_byte_n  (wr_byte_n),
      .lane_sel_n (lane_sel_n),
      .start      (start_w),
      .sel_ok     (sel_ok_w),
      .cpu_go     (cpu_go_w),
      .active     (active_w),
      .cur_addr   (cur_addr_w),
      .acc_kind   (acc_kind_w),
      .acc_addr   (acc_addr_w),
      .lane_we    (lane_we_w)
   );

   byte_array #(
      .LANES  (LANES),
      .LANE_W (LANE_W),
      .ADDR_W (ADDR_W)
   ) u_array (
      .clk     (clk),
      .lane_we (lane_we_w),
      .addr    (acc_addr_w),
      .wdata   (din),
      .rdata   (rdata_w)
   );

   assign rd_fire_w = (acc_kind_w == ACC_READ);

   read_pipe #(
      .DATA_W (DATA_W)
   ) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_fire (rd_fire_w),
      .rd_data (rdata_w),
      .oe_n    (oe_n),
      .dout    (dout),
      .out_vld (out_vld_w),
      .dout_en (dout_en)
   );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2,
   parameter int LANES   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              sel_ok,
   input logic              cpu_go,
   input logic              active,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              step_n,
   input logic              rd_fire,
   input logic [LANES-1:0]  lane_we,
   input logic              oe_n,
   input logic              dout_en
);

   // R1: a deselecting start leaves nothing to drive two edges later
   a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !sel_ok) |=> ##1 !dout_en);

   // R4: linear increment with wrap, upper bits fixed
   a_r4_linear_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !start && !step_n) |=>
         ((cur_addr[BURST_W-1:0] == BURST_W'($past(cur_addr[BURST_W-1:0]) + BURST_W'(1)))
          && (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W]))));

   // R5: no strobe and no advance keeps the address
   a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !start && step_n) |=> $stable(cur_addr));

   // R8: processor-strobe start never writes
   a_r8_cpu_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_go && sel_ok) |-> (lane_we == '0));

   // R9: a read reaches the output after the next edge
   a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |=> ##1 (dout_en || oe_n));

   // R10: output enable high means no drive
   a_r10_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dout_en);

   // R11: first cycle after a start from deselect is not driven
   a_r11_first_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (start && sel_ok && !active) |=> !dout_en);

endmodule

bind burst_sram burst_sram_chk #(
   .ADDR_W  (ADDR_W),
   .BURST_W (BURST_W),
   .LANES   (LANES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start_w),
   .sel_ok   (sel_ok_w),
   .cpu_go   (cpu_go_w),
   .active   (active_w),
   .cur_addr (cur_addr_w),
   .step_n   (step_n),
   .rd_fire  (rd_fire_w),
   .lane_we  (lane_we_w),
   .oe_n     (oe_n),
   .dout_en  (dout_en)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;

   localparam int AW    = 6;
   localparam int LN    = 4;
   localparam int LW    = 9;
   localparam int DW    = LN * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          sel_a_n, sel_b, sel_c_n;
   logic          cpu_strb_n, ctl_strb_n, step_n;
   logic          wr_all_n, wr_byte_n;
   logic [LN-1:0] lane_sel_n;
   logic          oe_n;
   logic [DW-1:0] din;
   logic [DW-1:0] dout;
   logic          dout_en;

   always #5 clk = ~clk;

   burst_sram u_burst_sram (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (addr),
      .sel_a_n    (sel_a_n),
      .sel_b      (sel_b),
      .sel_c_n    (sel_c_n),
      .cpu_strb_n (cpu_strb_n),
      .ctl_strb_n (ctl_strb_n),
      .step_n     (step_n),
      .wr_all_n   (wr_all_n),
      .wr_byte_n  (wr_byte_n),
      .lane_sel_n (lane_sel_n),
      .oe_n       (oe_n),
      .din        (din),
      .dout       (dout),
      .dout_en    (dout_en)
   );

   int    checks = 0;
   int    fails  = 0;
   string cur_req = "R12";

   // reference model state
   logic [DW-1:0] mm [DEPTH];
   bit            m_active = 1'b0;
   int            m_addr   = 0;
   bit            s1v = 1'b0, ov = 1'b0;
   logic [DW-1:0] s1d = '0, od = '0;

   task automatic chk(input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic compare();
      bit een;
      een = ov && !oe_n;
      chk(cur_req, DW'(dout_en), DW'(een), "drive");
      if (een) chk(cur_req, dout, od, "data");
   endtask

   task automatic model_step();
      bit selok, cg, st, wq, acc, wr;
      int a;
      selok = !sel_a_n && sel_b && !sel_c_n;
      cg    = !cpu_strb_n && !sel_a_n;
      st    = cg || !ctl_strb_n;
      wq    = !wr_all_n || !wr_byte_n;
      acc   = 1'b0;
      wr    = 1'b0;
      a     = m_addr;
      if (st) begin
         if (selok) begin
            m_active = 1'b1;
            a   = int'(addr);
            acc = 1'b1;
            wr  = !cg && wq;
         end else begin
            m_active = 1'b0;
         end
      end else if (m_active) begin
         if (!step_n) a = (m_addr & ~3) | ((m_addr + 1) & 3);
         acc = 1'b1;
         wr  = wq;
      end
      m_addr = a;
      ov  = s1v;
      od  = s1d;
      s1v = acc && !wr;
      s1d = mm[a];
      if (acc && wr) begin
         for (int l = 0; l < LN; l++) begin
            if (!wr_all_n || !lane_sel_n[l]) mm[a][l*LW +: LW] = din[l*LW +: LW];
         end
      end
   endtask

   task automatic cyc(input int a = 0, input bit cpu = 0, input bit ctl = 0,
                      input bit stp = 0, input bit wall = 0, input bit wbyte = 0,
                      input logic [LN-1:0] ls_n = '1, input logic [DW-1:0] d = '0,
                      input bit sa_n = 0, input bit sb = 1, input bit sc_n = 0);
      @(negedge clk);
      compare();
      addr       = AW'(a);
      cpu_strb_n = !cpu;
      ctl_strb_n = !ctl;
      step_n     = !stp;
      wr_all_n   = !wall;
      wr_byte_n  = !wbyte;
      lane_sel_n = ls_n;
      din        = d;
      sel_a_n    = sa_n;
      sel_b      = sb;
      sel_c_n    = sc_n;
      model_step();
   endtask

   function automatic logic [DW-1:0] patt(input int i);
      return DW'(64'(i) * 64'h0000_0012_3456_789B) ^ DW'(36'h5_A5A5_0F0F);
   endfunction

   initial begin
      rst_n = 1'b0;
      addr = '0; sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
      cpu_strb_n = 1'b1; ctl_strb_n = 1'b1; step_n = 1'b1;
      wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_sel_n = '1;
      oe_n = 1'b0; din = '0;
      // R12: reset state
      repeat (3) begin
         @(negedge clk);
         chk("R12", DW'(dout_en), '0, "drive in reset");
      end
      rst_n = 1'b1;

      // R2 / R6: fill every word with a controller-strobe global write
      cur_req = "R2";
      for (int i = 0; i < DEPTH; i++) cyc(.a(i), .ctl(1), .wall(1), .d(patt(i)));
      cyc(); cyc(); cyc();

      // R1: deselecting starts, then write attempts while deselected
      cur_req = "R1";
      cyc(.a(5), .ctl(1), .sb(0));
      cyc(.a(5), .wall(1), .d('1));
      cyc(.a(5), .ctl(1), .wall(1), .d('1), .sc_n(1));
      cyc(.a(5), .wall(1), .d('1));
      cyc();

      // R11: start a read from deselect; first cycle must not drive
      cur_req = "R11";
      cyc(.a(5), .cpu(1));
      cyc();
      cur_req = "R1";
      cyc(); cyc();

      // R8: processor start with write inputs asserted is a read
      cur_req = "R8";
      cyc(.a(6), .cpu(1), .wall(1), .wbyte(1), .ls_n('0), .d('1));
      // R4: advance 6 -> 7 -> 4 -> 5
      cur_req = "R4";
      cyc(.stp(1)); cyc(.stp(1)); cyc(.stp(1));
      // R5: hold
      cur_req = "R5";
      cyc(); cyc();
      // R3: processor strobe with sel_a_n high is ignored
      cur_req = "R3";
      cyc(.a(40), .cpu(1), .sa_n(1));
      cyc(); cyc();
      // R9: data of each read two edges later
      cur_req = "R9";
      cyc(.a(33), .ctl(1)); cyc(.stp(1)); cyc(); cyc();

      // R7: byte writes on lanes 0 and 2, then none
      cur_req = "R7";
      cyc(.a(10), .ctl(1), .wbyte(1), .ls_n(4'b1010), .d('1));
      cyc(.stp(1), .wbyte(1), .ls_n(4'b1111), .d('1));
      // R6: global write ignores byte controls
      cur_req = "R6";
      cyc(.stp(1), .wall(1), .ls_n(4'b1111), .d(36'h1_2345_6789));
      cur_req = "R7";
      cyc(.a(10), .ctl(1)); cyc(.stp(1)); cyc(.stp(1)); cyc(); cyc();
      // R1: word 5 untouched by deselected writes
      cur_req = "R1";
      cyc(.a(5), .ctl(1)); cyc(); cyc();

      // R10: asynchronous output enable
      cur_req = "R10";
      cyc(.a(20), .ctl(1)); cyc(); cyc();
      #2;
      oe_n = 1'b1;
      #1 chk("R10", DW'(dout_en), '0, "drive with oe high");
      oe_n = 1'b0;
      #1 chk("R10", DW'(dout_en), DW'(1), "drive with oe low");
      cyc(); cyc();

      cur_req = "R1";
      cyc(.ctl(1), .sb(0)); cyc(); cyc(); cyc();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule